// File: doc/BRIEF.md
# Optical Port Output Conditioner

This block sits between a meter's infrared serial port and the logic that feeds it. On the transmit side, a two-bit source select routes one of four signals toward the optical emitter pin: a general-purpose output bit, the UART transmit line, the real-energy pulse or the reactive-energy pulse. The routed signal may be inverted. After that it may be modulated by an externally supplied carrier, which fills only the intervals where the signal is low. A display-segment override takes the pin away from all four sources and drives the segment signal instead. The pin value is registered once on the system clock.

On the receive side, the optical comparator output goes to two consumers. The UART input receives it, optionally inverted. The general-purpose input path always receives it unmodified.

Control bits are loaded through a simple address/data/write-enable port. All of them clear on reset.

Top module: `optx_conditioner`

## Requirements
- R1: With override, invert and modulation all clear, source select value 0 drives the general-purpose bit to the pin, 1 drives UART transmit, 2 drives the real-energy pulse and 3 drives the reactive-energy pulse.
- R2: When the segment override bit is 1, the pin follows the segment input regardless of select, invert or modulation settings.
- R3: When the transmit invert bit is 1, the pin carries the complement of the selected source. The inversion is applied before modulation.
- R4: When modulation is enabled, the pin carries the carrier input while the post-inversion signal is 0, and carries 1 while that signal is 1.
- R5: The UART receive output equals the comparator input XOR the receive invert bit. The general-purpose receive output always equals the comparator input. Both are combinational.
- R6: After reset all control bits are 0 and the pin register holds 0. The first registered value is therefore the general-purpose bit, not inverted and not modulated.
- R7: Register address 0 holds select in bits [1:0], transmit invert in bit 2, modulation enable in bit 3 and segment override in bit 4. Address 1 holds receive invert in bit 0. A write takes effect on the clock edge that samples it. Writes to any other address change nothing.
- R8: The pin is registered. It changes only at a clock edge, to the value computed from the inputs and control bits present just before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 8 | Register write data |
| gpo_bit | input | 1 | General-purpose output bit source |
| uart_txd | input | 1 | UART transmit source |
| real_pulse | input | 1 | Real-energy pulse source |
| reac_pulse | input | 1 | Reactive-energy pulse source |
| seg_drive | input | 1 | Display segment drive used under override |
| carrier | input | 1 | Free-running modulation carrier |
| cmp_in | input | 1 | Optical receive comparator result |
| tx_pin | output | 1 | Conditioned optical transmit pin (registered) |
| uart_rxd | output | 1 | Receive data toward the UART |
| gpi_rxd | output | 1 | Receive data toward the general-purpose input path |

## Verification
The hardest case to reach from the ports is modulation combined with inversion. The carrier must toggle at the same moment the inverted source is low, and the pin must follow the carrier there and hold high elsewhere. The bench makes this happen often by randomizing every source and the carrier on every cycle. It also rewrites the control registers at short random intervals, so every combination of select, invert, modulation and override is held for several cycles. Some writes go to unused addresses, and the per-cycle model must show that they leave the pin untouched.

// File: rtl/optx_pkg.sv
package optx_pkg;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic             tx_inv;
        logic             mod_en;
        logic             seg_ovr;
        logic             rx_inv;
    } optx_ctrl_t;

    localparam logic [3:0] ADDR_TXCFG = 4'd0;
    localparam logic [3:0] ADDR_RXCFG = 4'd1;
endpackage

// File: rtl/optx_ctrl_regs.sv
module optx_ctrl_regs
    import optx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output optx_ctrl_t        ctrl
);
    localparam logic [ADDR_W-1:0] A_TX = ADDR_W'(ADDR_TXCFG);
    localparam logic [ADDR_W-1:0] A_RX = ADDR_W'(ADDR_RXCFG);

    optx_ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr_en && wr_addr == A_TX) begin
            ctrl_d.sel     = wr_data[SEL_W-1:0];
            ctrl_d.tx_inv  = wr_data[2];
            ctrl_d.mod_en  = wr_data[3];
            ctrl_d.seg_ovr = wr_data[4];
        end
        if (wr_en && wr_addr == A_RX) begin
            ctrl_d.rx_inv = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= '0;
        else        ctrl_q <= ctrl_d;
    end

    assign ctrl = ctrl_q;

    assert_tx_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_TX) |=> (ctrl_q.sel == $past(wr_data[SEL_W-1:0])
                                        && ctrl_q.seg_ovr == $past(wr_data[4])));
    assert_idle_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_q));
endmodule

// File: rtl/optx_tx_path.sv
module optx_tx_path
    import optx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  optx_ctrl_t ctrl,
    input  logic       gpo_bit,
    input  logic       uart_txd,
    input  logic       real_pulse,
    input  logic       reac_pulse,
    input  logic       seg_drive,
    input  logic       carrier,
    output logic       tx_pin
);
    typedef struct packed {
        logic pin;
    } tx_state_t;

    tx_state_t st_d, st_q;
    logic [NUM_SRC-1:0] srcs;
    logic               picked;
    logic               shaped;

    assign srcs = {reac_pulse, real_pulse, uart_txd, gpo_bit};

    always_comb begin
        picked = srcs[ctrl.sel];
        shaped = picked ^ ctrl.tx_inv;
        if (ctrl.mod_en && !shaped) shaped = carrier;
        st_d.pin = ctrl.seg_ovr ? seg_drive : shaped;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tx_pin = st_q.pin;

    assert_seg_override_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.seg_ovr |=> tx_pin == $past(seg_drive));
    assert_mod_high_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.seg_ovr && ctrl.mod_en && (srcs[ctrl.sel] != ctrl.tx_inv)) |=> tx_pin);
    assert_mod_low_carrier_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.seg_ovr && ctrl.mod_en && (srcs[ctrl.sel] == ctrl.tx_inv)) |=> tx_pin == $past(carrier));
    assert_plain_select_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.seg_ovr && !ctrl.mod_en && !ctrl.tx_inv && ctrl.sel == 2'd1) |=> tx_pin == $past(uart_txd));
endmodule

// File: rtl/optx_rx_path.sv
module optx_rx_path
    import optx_pkg::*;
(
    input  optx_ctrl_t ctrl,
    input  logic       cmp_in,
    output logic       uart_rxd,
    output logic       gpi_rxd
);
    always_comb begin
        uart_rxd = cmp_in ^ ctrl.rx_inv;
        gpi_rxd  = cmp_in;
    end

    always_comb begin
        assert_rx_split_R5: assert ((uart_rxd ^ gpi_rxd) == ctrl.rx_inv || $isunknown(cmp_in));
    end
endmodule

// File: rtl/optx_conditioner.sv
module optx_conditioner
    import optx_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              gpo_bit,
    input  logic              uart_txd,
    input  logic              real_pulse,
    input  logic              reac_pulse,
    input  logic              seg_drive,
    input  logic              carrier,
    input  logic              cmp_in,
    output logic              tx_pin,
    output logic              uart_rxd,
    output logic              gpi_rxd
);
    optx_ctrl_t ctrl;

    optx_ctrl_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl)
    );

    optx_tx_path u_tx (
        .clk(clk), .rst_n(rst_n), .ctrl(ctrl), .gpo_bit(gpo_bit),
        .uart_txd(uart_txd), .real_pulse(real_pulse), .reac_pulse(reac_pulse),
        .seg_drive(seg_drive), .carrier(carrier), .tx_pin(tx_pin)
    );

    optx_rx_path u_rx (
        .ctrl(ctrl), .cmp_in(cmp_in), .uart_rxd(uart_rxd), .gpi_rxd(gpi_rxd)
    );

    assert_gpi_untouched_R5: assert property (@(posedge clk) disable iff (!rst_n)
        gpi_rxd == cmp_in);
endmodule

// File: tb/test_optx_conditioner.sv
module test_optx_conditioner;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic gpo_bit = 0, uart_txd = 0, real_pulse = 0, reac_pulse = 0;
    logic seg_drive = 0, carrier = 0, cmp_in = 0;
    logic tx_pin, uart_rxd, gpi_rxd;

    int n_tests = 0;
    int n_fail  = 0;

    optx_conditioner i_optx_conditioner (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .gpo_bit(gpo_bit), .uart_txd(uart_txd), .real_pulse(real_pulse),
        .reac_pulse(reac_pulse), .seg_drive(seg_drive), .carrier(carrier),
        .cmp_in(cmp_in), .tx_pin(tx_pin), .uart_rxd(uart_rxd), .gpi_rxd(gpi_rxd)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int m_sel = 0, m_inv = 0, m_mod = 0, m_ovr = 0, m_rxinv = 0;
    bit exp_tx = 0;
    string exp_tag = "R6";

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_sel = 0; m_inv = 0; m_mod = 0; m_ovr = 0; m_rxinv = 0;
            exp_tx = 0; exp_tag = "R6";
        end else begin
            bit s;
            case (m_sel)
                0: s = gpo_bit;
                1: s = uart_txd;
                2: s = real_pulse;
                default: s = reac_pulse;
            endcase
            if (m_inv != 0) s = !s;
            if (m_mod != 0 && s == 0) s = carrier;
            if (m_ovr != 0) s = seg_drive;
            exp_tx = s;
            exp_tag = (m_ovr != 0) ? "R2" : (m_mod != 0) ? "R4" : (m_inv != 0) ? "R3" : "R1";
            if (wr_en) begin
                if (wr_addr == 0) begin
                    m_sel = int'(wr_data[1:0]); m_inv = wr_data[2];
                    m_mod = wr_data[3]; m_ovr = wr_data[4];
                end else if (wr_addr == 1) begin
                    m_rxinv = wr_data[0];
                end
                exp_tag = {exp_tag, "/R7"};
            end
        end
    end

    task automatic check(input string tag, input bit act, input bit exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        check(exp_tag, tx_pin, exp_tx);
        check("R5 uart", uart_rxd, cmp_in ^ m_rxinv[0]);
        check("R5 gpi", gpi_rxd, cmp_in);
    endtask

    task automatic randomize_inputs();
        {gpo_bit, uart_txd, real_pulse, reac_pulse, seg_drive, carrier, cmp_in} = 7'($urandom);
    endtask

    task automatic step();
        @(negedge clk);
        check_all();
        wr_en = 1'b0;
        randomize_inputs();
    endtask

    task automatic write_reg(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        check_all();
        randomize_inputs();
        wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    initial begin
        #5000000;
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R6 pin reset", tx_pin, 1'b0);
        rst_n = 1'b1;
        // R6: first cycles after reset route general-purpose bit
        gpo_bit = 1'b1;
        step();
        check("R6 gpo default", tx_pin, 1'b1);
        // R1: directed walk through each select value
        for (int s = 0; s < 4; s++) begin
            write_reg(4'd0, 8'(s));
            repeat (6) step();
        end
        // R8: input changes between edges do not reach the pin
        @(negedge clk);
        check_all();
        begin
            bit held;
            held = tx_pin;
            uart_txd = !uart_txd; gpo_bit = !gpo_bit; real_pulse = !real_pulse; reac_pulse = !reac_pulse;
            #2;
            check("R8 registered", tx_pin, held);
        end
        // R7: write to an unused address leaves the configuration alone
        write_reg(4'd0, 8'h0D);
        write_reg(4'd7, 8'hFF);
        repeat (4) step();
        // Random mixing of every mode
        for (int i = 0; i < 2000; i++) begin
            if ($urandom_range(0, 5) == 0)
                write_reg(4'($urandom_range(0, 3)), 8'($urandom));
            else
                step();
        end
        step();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule